// File: doc/BRIEF.md
# Upgrade Command Frame Parser

This block sits behind a byte receiver and turns a stream of bytes into upgrade commands for a flash array. It looks for a four-character sync header, reads a command byte that selects either programming or verifying, then reads a starting offset and a block count. It checks both values against the size of the flash space. For each block it assembles the incoming bytes into 32-bit data words and passes each word downstream with a one-cycle strobe. It keeps a running sum of the words and compares it with the checksum word that ends the block.

When a block's checksum matches, the parser holds and waits for the downstream logic to report that the block is done or has failed. It accepts no bytes while it waits. It then moves the block address on by one block, or goes back to hunting for a header once the count is used up. Every error is sticky until an acknowledge input, typically a push button, is asserted. A state code output drives a status display.

Top module: `flash_frame_parser`

## Requirements
- R1: The header is the byte sequence 0x4D, 0x50, 0x54, 0x21 ("MPT!"). The parser discards a byte that breaks the sequence and starts matching 0x4D again with the next byte, so "MMPT!" is not a header.
- R2: The byte after the header selects the command: 0x50 means program (`cmd_verify_o` = 0) and 0x56 means verify (`cmd_verify_o` = 1). Any other value returns the parser to the header hunt.
- R3: The parser then reads a 32-bit offset, least significant byte first. If the offset is not below SPACE_BLOCKS × 2^BLOCK_BITS bytes, or is not a multiple of 2^BLOCK_BITS, the parser enters the offset error (code 5).
- R4: A one-byte block count follows. A count of zero, or an offset plus count × 2^BLOCK_BITS that exceeds the space, causes the block-count error (code 6). An end that equals the space exactly is accepted.
- R5: Each block holds 2^(BLOCK_BITS-2) data words, each sent least significant byte first. On the clock edge that takes a word's fourth byte, the parser drives `word_o` with that word and pulses `word_valid_o` for one cycle.
- R6: A checksum word, least significant byte first, follows each block's data. It must equal the 32-bit wrapping sum of that block's data words. A mismatch is the checksum error (code 7).
- R7: After a good checksum, `blk_ready_o` is high until `blk_done_i` or `blk_err_i`, and every byte that arrives meanwhile is ignored. `blk_err_i` has priority over `blk_done_i` and gives the downstream error (code 8).
- R8: `blk_addr_o` starts at the offset. On each `blk_done_i` it advances by 2^BLOCK_BITS while blocks remain. After the last block the parser returns to the header hunt.
- R9: An error state holds its code and ignores all bytes. When `ack_i` is asserted, the parser returns to the header hunt on the next cycle.
- R10: The values of `state_o` are: 0 while waiting for a header or command, 1 while reading the parameters of a program command, 2 while reading the parameters of a verify command, 3 while reading block data or a checksum, 4 while holding for downstream, and 5 to 8 for the error kinds.
- R11: After reset, `state_o` is 0, and `word_valid_o` and `blk_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| ack_i | input | 1 | Error acknowledge (button) |
| blk_done_i | input | 1 | Downstream finished the held block |
| blk_err_i | input | 1 | Downstream failed the held block |
| cmd_verify_o | output | 1 | 1 = verify command, 0 = program command |
| blk_addr_o | output | 32 | Byte address of the current block |
| word_valid_o | output | 1 | One-cycle strobe for `word_o` |
| word_o | output | 32 | Assembled data word |
| blk_ready_o | output | 1 | Block checksum good, waiting for downstream |
| state_o | output | 4 | Display state code |

## Verification
The bench builds the parser with BLOCK_BITS = 4 and SPACE_BLOCKS = 8. This gives 16-byte blocks of four words in a 128-byte space, so whole multi-block commands, the last block in the space and offsets just past the end can be exercised in a few hundred cycles. Misalignment by a single word and count overruns by one block are reachable with the same small numbers. A behavioural model that tracks phases with integers predicts every output on every clock.

// File: rtl/flash_frame_parser.sv
module flash_frame_parser #(
  parameter int BLOCK_BITS   = 18,
  parameter int SPACE_BLOCKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        ack_i,
  input  logic        blk_done_i,
  input  logic        blk_err_i,
  output logic        cmd_verify_o,
  output logic [31:0] blk_addr_o,
  output logic        word_valid_o,
  output logic [31:0] word_o,
  output logic        blk_ready_o,
  output logic [3:0]  state_o
);
  localparam int          WCW       = BLOCK_BITS - 2;
  localparam logic [32:0] BLK_SZ    = 33'(1) << BLOCK_BITS;
  localparam logic [32:0] SPACE     = 33'(SPACE_BLOCKS) << BLOCK_BITS;
  localparam logic [31:0] LOW_MASK  = 32'(BLK_SZ - 33'(1));
  localparam logic [3:0]  C_WAIT = 4'd0, C_PROG = 4'd1, C_VER = 4'd2, C_READ = 4'd3,
                          C_HOLD = 4'd4, C_EOFF = 4'd5, C_ECNT = 4'd6, C_ESUM = 4'd7,
                          C_EDN  = 4'd8;

  typedef enum logic [2:0] {S_HUNT, S_CMD, S_OFF, S_CNT, S_DATA, S_SUM, S_HOLD, S_ERR} st_t;

  st_t             st;
  logic [1:0]      hidx, lane;
  logic [23:0]     shreg;
  logic [31:0]     sum;
  logic [WCW-1:0]  wcnt;
  logic [7:0]      left;
  logic [3:0]      ecode;

  wire [31:0] nxt_word = {rx_byte, shreg};
  wire        off_bad  = ({1'b0, nxt_word} >= SPACE) || ((nxt_word & LOW_MASK) != 32'd0);
  wire [32:0] end_addr = {1'b0, blk_addr_o} + (33'(rx_byte) << BLOCK_BITS);
  wire        cnt_bad  = (rx_byte == 8'd0) || (end_addr > SPACE);

  function automatic logic [7:0] hdr_char(input logic [1:0] i);
    case (i)
      2'd0:    hdr_char = 8'h4D;
      2'd1:    hdr_char = 8'h50;
      2'd2:    hdr_char = 8'h54;
      default: hdr_char = 8'h21;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT; hidx <= '0; lane <= '0; shreg <= '0; sum <= '0; wcnt <= '0;
      left <= '0; ecode <= C_EOFF; cmd_verify_o <= 1'b0; blk_addr_o <= '0;
      word_valid_o <= 1'b0; word_o <= '0;
    end else begin
      word_valid_o <= 1'b0;
      case (st)
        S_HUNT: if (rx_valid) begin
          if (rx_byte == hdr_char(hidx)) begin
            hidx <= hidx + 2'd1;
            if (hidx == 2'd3) st <= S_CMD;
          end else hidx <= '0;
        end
        S_CMD: if (rx_valid) begin
          lane <= '0;
          if (rx_byte == 8'h50) begin cmd_verify_o <= 1'b0; st <= S_OFF; end
          else if (rx_byte == 8'h56) begin cmd_verify_o <= 1'b1; st <= S_OFF; end
          else st <= S_HUNT;
        end
        S_OFF: if (rx_valid) begin
          shreg <= nxt_word[31:8];
          lane  <= lane + 2'd1;
          if (lane == 2'd3) begin
            if (off_bad) begin st <= S_ERR; ecode <= C_EOFF; end
            else begin blk_addr_o <= nxt_word; st <= S_CNT; end
          end
        end
        S_CNT: if (rx_valid) begin
          if (cnt_bad) begin st <= S_ERR; ecode <= C_ECNT; end
          else begin
            left <= rx_byte; st <= S_DATA; sum <= '0; wcnt <= '0; lane <= '0;
          end
        end
        S_DATA: if (rx_valid) begin
          shreg <= nxt_word[31:8];
          lane  <= lane + 2'd1;
          if (lane == 2'd3) begin
            word_valid_o <= 1'b1;
            word_o       <= nxt_word;
            sum          <= sum + nxt_word;
            wcnt         <= wcnt + 1'b1;
            if (&wcnt) st <= S_SUM;
          end
        end
        S_SUM: if (rx_valid) begin
          shreg <= nxt_word[31:8];
          lane  <= lane + 2'd1;
          if (lane == 2'd3) begin
            if (nxt_word == sum) st <= S_HOLD;
            else begin st <= S_ERR; ecode <= C_ESUM; end
          end
        end
        S_HOLD: begin
          if (blk_err_i) begin st <= S_ERR; ecode <= C_EDN; end
          else if (blk_done_i) begin
            if (left == 8'd1) begin st <= S_HUNT; hidx <= '0; end
            else begin
              left <= left - 8'd1; blk_addr_o <= blk_addr_o + 32'(BLK_SZ);
              st <= S_DATA; sum <= '0; wcnt <= '0; lane <= '0;
            end
          end
        end
        default: if (ack_i) begin st <= S_HUNT; hidx <= '0; end
      endcase
    end
  end

  assign blk_ready_o = (st == S_HOLD);

  always_comb begin
    case (st)
      S_OFF, S_CNT:  state_o = cmd_verify_o ? C_VER : C_PROG;
      S_DATA, S_SUM: state_o = C_READ;
      S_HOLD:        state_o = C_HOLD;
      S_ERR:         state_o = ecode;
      default:       state_o = C_WAIT;
    endcase
  end
endmodule

module flash_frame_parser_chk #(
  parameter int BLOCK_BITS = 18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        ack_i,
  input logic        blk_done_i,
  input logic        blk_err_i,
  input logic [31:0] blk_addr_o,
  input logic        word_valid_o,
  input logic        blk_ready_o,
  input logic [3:0]  state_o
);
  localparam logic [31:0] BLK = 32'(33'(1) << BLOCK_BITS);

  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (state_o == 4'd3) && $past(rx_valid));

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready_o && !blk_done_i && !blk_err_i) |=> blk_ready_o && (state_o == 4'd4));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready_o && blk_done_i && !blk_err_i) |=>
      (state_o == 4'd0) || (blk_addr_o == $past(blk_addr_o) + BLK));

  // R9
  err_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o >= 4'd5 && !ack_i) |=> $stable(state_o));

  // R9
  err_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o >= 4'd5 && ack_i) |=> (state_o == 4'd0));
endmodule

bind flash_frame_parser flash_frame_parser_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ack_i(ack_i),
  .blk_done_i(blk_done_i), .blk_err_i(blk_err_i), .blk_addr_o(blk_addr_o),
  .word_valid_o(word_valid_o), .blk_ready_o(blk_ready_o), .state_o(state_o)
);

// File: tb/sim_flash_frame_parser.sv
module sim_flash_frame_parser;
  localparam int CLK_NS = 10;
  localparam int BB = 4;
  localparam int SB = 8;
  localparam int BLK = 1 << BB;
  localparam int SPACE = SB * BLK;
  localparam int WPB = BLK / 4;

  logic clk = 0, rst_n = 0, rx_valid = 0, ack_i = 0, blk_done_i = 0, blk_err_i = 0;
  logic [7:0] rx_byte = 0;
  logic cmd_verify_o, word_valid_o, blk_ready_o;
  logic [31:0] blk_addr_o, word_o;
  logic [3:0] state_o;

  int tests = 0, fails = 0, cyc = 0;

  flash_frame_parser #(.BLOCK_BITS(BB), .SPACE_BLOCKS(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .ack_i(ack_i),
    .blk_done_i(blk_done_i), .blk_err_i(blk_err_i), .cmd_verify_o(cmd_verify_o),
    .blk_addr_o(blk_addr_o), .word_valid_o(word_valid_o), .word_o(word_o),
    .blk_ready_o(blk_ready_o), .state_o(state_o));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model: phase 0 hunt,1 cmd,2 offset,3 count,4 data,5 checksum,6 hold,7 error
  logic [7:0] hdr [4] = '{8'h4D, 8'h50, 8'h54, 8'h21};
  int ph = 0, hpos = 0, nb = 0, m_left = 0, m_words = 0, m_err = 0;
  logic [31:0] acc = 0, m_addr = 0, m_sum = 0, m_word = 0;
  bit m_ver = 0, m_wv = 0;

  always @(posedge clk) begin
    m_wv = 0;
    if (!rst_n) begin
      ph = 0; hpos = 0; nb = 0; m_ver = 0; m_addr = 0;
    end else begin
      case (ph)
        0: if (rx_valid) begin
             if (rx_byte == hdr[hpos]) begin hpos++; if (hpos == 4) begin ph = 1; hpos = 0; end end
             else hpos = 0;
           end
        1: if (rx_valid) begin
             if (rx_byte == 8'h50) begin m_ver = 0; ph = 2; nb = 0; end
             else if (rx_byte == 8'h56) begin m_ver = 1; ph = 2; nb = 0; end
             else ph = 0;
           end
        2: if (rx_valid) begin
             acc = (acc >> 8) | (32'(rx_byte) << 24); nb++;
             if (nb == 4) begin
               nb = 0;
               if (longint'(acc) >= SPACE || (acc % BLK) != 0) begin ph = 7; m_err = 5; end
               else begin m_addr = acc; ph = 3; end
             end
           end
        3: if (rx_valid) begin
             if (rx_byte == 0 || longint'(m_addr) + longint'(rx_byte) * BLK > SPACE) begin
               ph = 7; m_err = 6;
             end else begin m_left = rx_byte; ph = 4; m_sum = 0; m_words = 0; nb = 0; end
           end
        4: if (rx_valid) begin
             acc = (acc >> 8) | (32'(rx_byte) << 24); nb++;
             if (nb == 4) begin
               nb = 0; m_wv = 1; m_word = acc; m_sum = m_sum + acc; m_words++;
               if (m_words == WPB) ph = 5;
             end
           end
        5: if (rx_valid) begin
             acc = (acc >> 8) | (32'(rx_byte) << 24); nb++;
             if (nb == 4) begin
               nb = 0;
               if (acc == m_sum) ph = 6; else begin ph = 7; m_err = 7; end
             end
           end
        6: if (blk_err_i) begin ph = 7; m_err = 8; end
           else if (blk_done_i) begin
             m_left--;
             if (m_left == 0) begin ph = 0; hpos = 0; end
             else begin m_addr = m_addr + BLK; ph = 4; m_sum = 0; m_words = 0; nb = 0; end
           end
        default: if (ack_i) begin ph = 0; hpos = 0; end
      endcase
    end
  end

  function automatic logic [3:0] exp_code();
    case (ph)
      0, 1: return 4'd0;
      2, 3: return m_ver ? 4'd2 : 4'd1;
      4, 5: return 4'd3;
      6:    return 4'd4;
      default: return 4'(m_err);
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 state_o", 32'(state_o), 32'(exp_code()));
      chk("R5 word_valid_o", 32'(word_valid_o), 32'(m_wv));
      if (m_wv) chk("R5 word_o", word_o, m_word);
      chk("R7 blk_ready_o", 32'(blk_ready_o), 32'(ph == 6));
      if (ph >= 4 && ph <= 6) chk("R8 blk_addr_o", blk_addr_o, m_addr);
      if (ph >= 2 && ph <= 6) chk("R2 cmd_verify_o", 32'(cmd_verify_o), 32'(m_ver));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic put(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0; @(negedge clk);
  endtask
  task automatic put_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) put(w[8*i +: 8]);
  endtask
  task automatic header(input logic [7:0] c);
    put(8'h4D); put(8'h50); put(8'h54); put(8'h21); put(c);
  endtask
  task automatic put_block(input int seed, input bit bad);
    logic [31:0] s = 0;
    for (int i = 0; i < WPB; i++) begin
      logic [31:0] w = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h01020304 + 32'hF0000000;
      s = s + w; put_word(w);
    end
    put_word(bad ? s ^ 32'h1 : s);
  endtask
  task automatic done_pulse(input bit err);
    blk_err_i = err; blk_done_i = !err; @(negedge clk); blk_done_i = 0; blk_err_i = 0; @(negedge clk);
  endtask
  task automatic acknowledge();
    ack_i = 1; @(negedge clk); ack_i = 0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state_o", 32'(state_o), 0);
    chk("R11 reset word_valid_o", 32'(word_valid_o), 0);
    chk("R11 reset blk_ready_o", 32'(blk_ready_o), 0);
    rst_n = 1; @(negedge clk);

    put(8'h4D); put(8'h4D); put(8'h50); put(8'h54); put(8'h21); put(8'h50);
    chk("R1 doubled first char not a header", 32'(state_o), 0);
    header(8'h58);
    chk("R2 unknown command back to hunt", 32'(state_o), 0);
    put(8'h50);
    chk("R2 stray command byte after hunt", 32'(state_o), 0);

    header(8'h50);
    chk("R2 program parameter state", 32'(state_o), 1);
    put_word(32'h10); put(8'd2);
    chk("R8 first address", blk_addr_o, 32'h10);
    put_block(1, 0);
    chk("R7 ready after good sum", 32'(blk_ready_o), 1);
    put(8'h4D); put(8'h50); put(8'h54); put(8'h21); put(8'h50);
    chk("R7 bytes ignored in hold", 32'(state_o), 4);
    done_pulse(0);
    chk("R8 address advanced", blk_addr_o, 32'h20);
    put_block(2, 0);
    done_pulse(0);
    chk("R8 back to hunt after count", 32'(state_o), 0);
    put(8'h50);
    chk("R7 held header bytes not counted", 32'(state_o), 0);

    header(8'h56);
    chk("R2 verify parameter state", 32'(state_o), 2);
    put_word(32'h70); put(8'd1);
    chk("R4 last block exactly fits", 32'(state_o), 3);
    put_block(3, 0); done_pulse(0);
    chk("R8 single block done", 32'(state_o), 0);

    header(8'h50); put_word(32'h80);
    chk("R3 offset at space end", 32'(state_o), 5);
    put(8'h4D); repeat (5) @(negedge clk);
    chk("R9 error holds", 32'(state_o), 5);
    acknowledge();
    chk("R9 ack clears", 32'(state_o), 0);

    header(8'h50); put_word(32'h14);
    chk("R3 misaligned offset", 32'(state_o), 5);
    acknowledge();
    header(8'h50); put_word(32'h0100_0000);
    chk("R3 high byte offset", 32'(state_o), 5);
    acknowledge();

    header(8'h56); put_word(32'h0); put(8'd0);
    chk("R4 zero count", 32'(state_o), 6);
    acknowledge();
    header(8'h50); put_word(32'h60); put(8'd3);
    chk("R4 count overruns space", 32'(state_o), 6);
    acknowledge();

    header(8'h50); put_word(32'h30); put(8'd1); put_block(4, 1);
    chk("R6 bad checksum", 32'(state_o), 7);
    acknowledge();

    header(8'h50); put_word(32'h40); put(8'd2); put_block(5, 0);
    blk_done_i = 1; blk_err_i = 1; @(negedge clk); blk_done_i = 0; blk_err_i = 0; @(negedge clk);
    chk("R7 downstream error priority", 32'(state_o), 8);
    acknowledge();
    chk("R9 recovered", 32'(state_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule